// File: doc/BRIEF.md
# Boot ROM Shadowing Remap Controller

This block steers the address decoder through the start-up sequence of a system that runs its operating system from a RAM copy of a ROM image. It sees every CPU bus cycle: a valid strobe, a write qualifier, the address and the write data. From these and its own mode it drives select overrides for three targets: the boot ROM, the original OS ROM and the shadow RAM. It also drives an override that makes the motherboard decoder stand aside, and a write-inhibit that discards a write.

After a hardware reset the boot ROM answers at every address, so the reset vector fetch lands in it. Boot software then writes a control register that sits in an otherwise unused I/O location. It first restores the OS ROM in the low window while it keeps running from a boot ROM alias at the top of the map. Next it selects a split mode, in which reads of the low window come from the OS ROM while writes to the same addresses land in the RAM beneath. It can also select a RAM test mode, in which the low window is plain read/write RAM. Last it selects the normal map, in which RAM fills the low window and the boot alias is gone. Write protection of the shadow RAM can be switched on and off at any time. A protected write is dropped without a bus error and sets a sticky flag. A software-invoked restart clears that flag but leaves the map as it is, so the OS restarts from the RAM copy. Only a hardware reset brings back the all-alias state.

Top module: `bsr_remap_ctl`

## Requirements
- R1: After hardware reset the mode is ALIAS (code 0), protection is off and the violation flag is clear. In ALIAS, every valid bus cycle other than a control register access asserts sel_boot_rom, and every such write also asserts wr_inhibit.
- R2: A read at CTRL_ADDR (default 0x1C000) returns {viol at bit 7, zeros at bits 6:4, wp at bit 3, mode at bits 2:0}. rd_data is zero for every other cycle.
- R3: Mode codes are ALIAS=0, OSROM=1, SPLIT=2, RAMTEST=3, NORMAL=4. A register write may keep the current mode or make one of these steps: 0→1, 1→2, 1→3, 2→3, 3→2, 2→4, 3→4. Any other requested code leaves the mode unchanged while bit 3 still sets wp. A write with any of bits 7:4 set is discarded entirely.
- R4: In OSROM, reads of the low window (address bits 19:16 all zero) assert sel_os_rom and writes there assert wr_inhibit. Any cycle in the boot alias slot (address bits 19:14 all one) asserts sel_boot_rom, and writes there are also inhibited. Other addresses get no override. A read never asserts wr_inhibit.
- R5: In SPLIT, low-window reads assert sel_os_rom and low-window writes assert sel_shadow_ram. The boot alias slot behaves as in R4.
- R6: In RAMTEST, low-window reads and writes both assert sel_shadow_ram. The boot alias slot behaves as in R4.
- R7: In NORMAL, low-window reads and writes assert sel_shadow_ram and the boot alias slot gets no override. NORMAL is left only by hardware reset.
- R8: In SPLIT, RAMTEST and NORMAL with wp set, a low-window write asserts wr_inhibit instead of sel_shadow_ram and sets the sticky violation flag. Clearing wp restores writes to RAM.
- R9: A soft_rst pulse clears the violation flag and keeps mode and wp. A violating write in the same cycle as soft_rst leaves the flag set.
- R10: A control register access asserts decode_override and none of the selects or wr_inhibit. A register write affects decoding from the next cycle on. decode_override is high exactly when a select, wr_inhibit or a control access is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| soft_rst | input | 1 | Software-invoked restart pulse |
| bus_valid | input | 1 | A bus cycle is present |
| bus_wr | input | 1 | The bus cycle is a write |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| rd_data | output | DATA_W | Control register read data |
| sel_boot_rom | output | 1 | Select boot ROM |
| sel_os_rom | output | 1 | Select original OS ROM |
| sel_shadow_ram | output | 1 | Select RAM under the low window |
| decode_override | output | 1 | Motherboard decoder must stand aside |
| wr_inhibit | output | 1 | Discard this write |

## Verification
Two events can meet in one cycle. A soft restart clears the violation flag, and a protected write to the low window sets it. The bench drives soft_rst high during a protected write in NORMAL and expects the flag to read back as set. A soft restart alone must read back as cleared. A second meeting is a control register write and the decode of that same cycle: the bench checks that the write cycle carries no overlay and that the following cycle already decodes under the new mode.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        MODE_ALIAS   = 3'd0,
        MODE_OSROM   = 3'd1,
        MODE_SPLIT   = 3'd2,
        MODE_RAMTEST = 3'd3,
        MODE_NORMAL  = 3'd4
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  wp;
        logic  viol;
    } ctl_s;

    typedef struct packed {
        logic boot;
        logic osrom;
        logic ram;
        logic inhibit;
        logic viol;
    } route_s;

    // Permitted mode steps; staying in the current mode is always allowed.
    function automatic logic step_ok(mode_e cur, logic [2:0] req);
        logic ok;
        case (cur)
            MODE_ALIAS:   ok = (req == 3'd0) || (req == 3'd1);
            MODE_OSROM:   ok = (req == 3'd1) || (req == 3'd2) || (req == 3'd3);
            MODE_SPLIT,
            MODE_RAMTEST: ok = (req == 3'd2) || (req == 3'd3) || (req == 3'd4);
            MODE_NORMAL:  ok = (req == 3'd4);
            default:      ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bsr_addr_class.sv
module bsr_addr_class #(
    parameter int ADDR_W    = 20,
    parameter int LOW_BITS  = 16,
    parameter int BOOT_BITS = 14,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'h1C000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_low,
    output logic              is_boot,
    output logic              is_ctrl
);
    localparam int LOW_TOP  = ADDR_W - LOW_BITS;
    localparam int BOOT_TOP = ADDR_W - BOOT_BITS;

    always_comb begin
        is_low  = (addr[ADDR_W-1:LOW_BITS]  == {LOW_TOP{1'b0}});
        is_boot = (addr[ADDR_W-1:BOOT_BITS] == {BOOT_TOP{1'b1}});
        is_ctrl = (addr == CTRL_ADDR);
    end
endmodule

// File: rtl/bsr_overlay_dec.sv
module bsr_overlay_dec
    import bsr_pkg::*;
(
    input  mode_e  mode,
    input  logic   wp,
    input  logic   valid,
    input  logic   wr,
    input  logic   is_low,
    input  logic   is_boot,
    input  logic   is_ctrl,
    output route_s route
);
    always_comb begin
        route = '0;
        if (valid && !is_ctrl) begin
            case (mode)
                MODE_ALIAS: begin
                    route.boot    = 1'b1;
                    route.inhibit = wr;
                end
                MODE_OSROM, MODE_SPLIT, MODE_RAMTEST, MODE_NORMAL: begin
                    if (is_low) begin
                        if (!wr) begin
                            route.osrom = (mode == MODE_OSROM) || (mode == MODE_SPLIT);
                            route.ram   = (mode == MODE_RAMTEST) || (mode == MODE_NORMAL);
                        end else if (mode == MODE_OSROM) begin
                            route.inhibit = 1'b1;
                        end else if (wp) begin
                            route.inhibit = 1'b1;
                            route.viol    = 1'b1;
                        end else begin
                            route.ram = 1'b1;
                        end
                    end else if (is_boot && mode != MODE_NORMAL) begin
                        route.boot    = 1'b1;
                        route.inhibit = wr;
                    end
                end
                default: route = '0;
            endcase
        end
    end
endmodule

// File: rtl/bsr_ctl_fsm.sv
module bsr_ctl_fsm
    import bsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              viol_evt,
    output ctl_s              ctl_q
);
    localparam int WP_BIT  = 3;
    localparam int RES_LSB = 4;

    ctl_s ctl_d;
    logic reserved;

    always_comb begin
        ctl_d    = ctl_q;
        reserved = |wdata[DATA_W-1:RES_LSB];
        if (ctl_wr && !reserved) begin
            ctl_d.wp = wdata[WP_BIT];
            if (step_ok(ctl_q.mode, wdata[2:0])) begin
                ctl_d.mode = mode_e'(wdata[2:0]);
            end
        end
        if (soft_rst) begin
            ctl_d.viol = 1'b0;
        end
        if (viol_evt) begin
            ctl_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_ALIAS, wp: 1'b0, viol: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/bsr_remap_ctl.sv
module bsr_remap_ctl
    import bsr_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int LOW_BITS  = 16,
    parameter int BOOT_BITS = 14,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'h1C000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              sel_boot_rom,
    output logic              sel_os_rom,
    output logic              sel_shadow_ram,
    output logic              decode_override,
    output logic              wr_inhibit
);
    logic   is_low, is_boot, is_ctrl;
    logic   ctl_hit;
    ctl_s   ctl;
    route_s route;

    bsr_addr_class #(
        .ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS),
        .BOOT_BITS(BOOT_BITS), .CTRL_ADDR(CTRL_ADDR)
    ) u_class (
        .addr(bus_addr), .is_low(is_low), .is_boot(is_boot), .is_ctrl(is_ctrl)
    );

    bsr_overlay_dec u_dec (
        .mode(ctl.mode), .wp(ctl.wp), .valid(bus_valid), .wr(bus_wr),
        .is_low(is_low), .is_boot(is_boot), .is_ctrl(is_ctrl), .route(route)
    );

    assign ctl_hit = bus_valid && is_ctrl;

    bsr_ctl_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ctl_wr(ctl_hit && bus_wr), .wdata(bus_wdata),
        .viol_evt(route.viol), .ctl_q(ctl)
    );

    always_comb begin
        rd_data = '0;
        if (ctl_hit && !bus_wr) begin
            rd_data[DATA_W-1] = ctl.viol;
            rd_data[3]        = ctl.wp;
            rd_data[2:0]      = ctl.mode;
        end
        sel_boot_rom    = route.boot;
        sel_os_rom      = route.osrom;
        sel_shadow_ram  = route.ram;
        wr_inhibit      = route.inhibit;
        decode_override = route.boot | route.osrom | route.ram | route.inhibit | ctl_hit;
    end
endmodule

// File: rtl/bsr_remap_chk.sv
module bsr_remap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       bus_valid,
    input logic       bus_wr,
    input logic [2:0] mode,
    input logic       wp,
    input logic       viol,
    input logic       sel_boot_rom,
    input logic       sel_os_rom,
    input logic       sel_shadow_ram,
    input logic       wr_inhibit
);
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_boot_rom, sel_os_rom, sel_shadow_ram})); // R4

    AST_READ_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_wr) |-> !wr_inhibit); // R4

    AST_INHIBIT_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> !sel_shadow_ram); // R8

    AST_ALIAS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> (mode == 3'd0 || mode == 3'd1)); // R3

    AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> (mode == 3'd4)); // R7

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !soft_rst) |=> viol); // R9

    AST_SOFT_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !(bus_valid && bus_wr)) |=> ($stable(mode) && $stable(wp))); // R9
endmodule

bind bsr_remap_ctl bsr_remap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_valid(bus_valid), .bus_wr(bus_wr),
    .mode(ctl.mode), .wp(ctl.wp), .viol(ctl.viol),
    .sel_boot_rom(sel_boot_rom), .sel_os_rom(sel_os_rom),
    .sel_shadow_ram(sel_shadow_ram), .wr_inhibit(wr_inhibit)
);

// File: tb/bsr_remap_ctl_tb.sv
`timescale 1ns/1ps
module bsr_remap_ctl_tb;
    localparam logic [19:0] CTRL = 20'h1C000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_wr = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic        sel_boot_rom, sel_os_rom, sel_shadow_ram, decode_override, wr_inhibit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bsr_remap_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data),
        .sel_boot_rom(sel_boot_rom), .sel_os_rom(sel_os_rom),
        .sel_shadow_ram(sel_shadow_ram), .decode_override(decode_override),
        .wr_inhibit(wr_inhibit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input bit wr, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = v; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #5;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, '0);
    endtask

    task automatic reg_wr(input logic [7:0] d);
        drive(1'b1, 1'b1, CTRL, d);
    endtask

    task automatic reg_rd(output logic [7:0] r);
        drive(1'b1, 1'b0, CTRL, '0);
        r = rd_data;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_valid = 1'b0; soft_rst = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic goto_mode(input int m);
        hw_reset();
        if (m >= 1) reg_wr(8'h01);
        if (m == 2 || m == 4) reg_wr(8'h02);
        if (m == 3) reg_wr(8'h03);
        if (m == 4) reg_wr(8'h04);
        idle();
    endtask

    function automatic bit legal(int cur, int req);
        case (cur)
            0: return req == 0 || req == 1;
            1: return req >= 1 && req <= 3;
            2, 3: return req >= 2 && req <= 4;
            4: return req == 4;
            default: return 1'b0;
        endcase
    endfunction

    // expected {boot, os, ram, inhibit, override, viol_set}
    function automatic logic [5:0] model(int m, bit wp, bit wr, logic [19:0] a);
        bit lo, bt, bo, os, rm, inh, vs;
        lo = (a[19:16] == 4'h0); bt = (a[19:14] == 6'h3F);
        bo = 0; os = 0; rm = 0; inh = 0; vs = 0;
        if (a == CTRL) return 6'b000010;
        if (m == 0) begin bo = 1; inh = wr; end
        else if (lo) begin
            if (!wr) begin os = (m == 1 || m == 2); rm = (m == 3 || m == 4); end
            else if (m == 1) inh = 1;
            else if (wp) begin inh = 1; vs = 1; end
            else rm = 1;
        end else if (bt && m != 4) begin bo = 1; inh = wr; end
        return {bo, os, rm, inh, bo | os | rm | inh, vs};
    endfunction

    function automatic logic [19:0] addr_at(int i);
        case (i)
            0: return 20'h00000; 1: return 20'h0FFFF; 2: return 20'h10000;
            3: return CTRL;      4: return 20'h20000; 5: return 20'h80000;
            6: return 20'hFC000; default: return 20'hFFFFF;
        endcase
    endfunction

    function automatic string mreq(int m);
        case (m)
            0: return "R1"; 1: return "R4"; 2: return "R5";
            3: return "R6"; default: return "R7";
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [5:0] e;
        bit vexp;

        // R1: reset state
        hw_reset();
        reg_rd(r);
        chk("R1 reset register", r, 8'h00);
        idle();
        chk("R2 rd_data idle", rd_data, 8'h00);
        drive(1'b1, 1'b0, 20'h00000, '0);
        chk("R2 rd_data non-ctrl read", rd_data, 8'h00);

        // R3: transition sweep, wp bit always requested
        for (int from = 0; from < 5; from++) begin
            for (int req = 0; req < 8; req++) begin
                goto_mode(from);
                reg_wr(8'h08 | req[7:0]);
                reg_rd(r);
                chk($sformatf("R3 step %0d->%0d", from, req), r,
                    {4'h0, 1'b1, (legal(from, req) ? req[2:0] : from[2:0])});
            end
        end
        goto_mode(1);
        reg_wr(8'h1A);
        reg_rd(r);
        chk("R3 reserved bits discard", r, 8'h01);

        // R4..R8: decode sweep over modes, protection, addresses, direction
        for (int m = 0; m < 5; m++) begin
            for (int wp = 0; wp < 2; wp++) begin
                goto_mode(m);
                reg_wr({4'h0, wp[0], m[2:0]});
                vexp = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        if (i == 3 && wr == 1) continue;
                        e = model(m, wp[0], wr[0], addr_at(i));
                        drive(1'b1, wr[0], addr_at(i), 8'h00);
                        chk($sformatf("%s%s m%0d wp%0d a%0h w%0d", mreq(m),
                            (wp != 0 && m >= 2) ? "/R8" : "", m, wp, addr_at(i), wr),
                            {sel_boot_rom, sel_os_rom, sel_shadow_ram, wr_inhibit, decode_override},
                            e[5:1]);
                        vexp = vexp | e[0];
                        if (wr == 1) begin
                            reg_rd(r);
                            chk($sformatf("R2/R8 readback m%0d wp%0d a%0h", m, wp, addr_at(i)),
                                r, {vexp, 3'b000, wp[0], m[2:0]});
                        end
                    end
                end
            end
        end

        // R8: protection is reversible
        goto_mode(4);
        reg_wr(8'h0C);
        drive(1'b1, 1'b1, 20'h00100, '0);
        chk("R8 protected write inhibited", {sel_shadow_ram, wr_inhibit}, 2'b01);
        reg_wr(8'h04);
        drive(1'b1, 1'b1, 20'h00100, '0);
        chk("R8 unprotected write to ram", {sel_shadow_ram, wr_inhibit}, 2'b10);

        // R9: soft restart clears the flag, keeps map
        reg_rd(r);
        chk("R9 viol set before soft restart", r, 8'h84);
        @(negedge clk); bus_valid = 1'b0; soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        reg_rd(r);
        chk("R9 soft restart clears viol keeps mode", r, 8'h04);
        reg_wr(8'h0C);
        @(negedge clk);
        bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = 20'h00200; soft_rst = 1'b1;
        #5;
        chk("R9 collision write inhibited", wr_inhibit, 1'b1);
        @(negedge clk); soft_rst = 1'b0; bus_valid = 1'b0;
        reg_rd(r);
        chk("R9 collision leaves viol set", r, 8'h8C);

        // R7: soft restart does not bring back the alias map
        @(negedge clk); bus_valid = 1'b0; soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        drive(1'b1, 1'b0, 20'hFC000, '0);
        chk("R7 no alias after soft restart", {sel_boot_rom, decode_override}, 2'b00);

        // R10: register write cycle carries no overlay, new mode next cycle
        hw_reset();
        reg_wr(8'h01);
        chk("R10 ctrl write cycle outputs",
            {sel_boot_rom, sel_os_rom, sel_shadow_ram, wr_inhibit, decode_override}, 5'b00001);
        drive(1'b1, 1'b0, 20'h00000, '0);
        chk("R10 next cycle uses new mode", {sel_boot_rom, sel_os_rom}, 2'b01);
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule